// File: doc/BRIEF.md
# Keyed Decrementer Timer

This block is a 32-bit down-counter that loses one count on each timebase tick while its enable bit is set. When the counter's most significant bit goes from 0 to 1, the block raises an interrupt request. That transition happens when the count wraps past zero. It can also happen when software loads a value with the top bit set. The request is held in a sticky pending flag until the core acknowledges it. Each such transition also gives a one-cycle wake-up pulse to the power-down logic.

Software reaches the block through a small register port with four word addresses: the count, a control word, an unlock key and a reserved slot. A write to the count takes effect only while the block is unlocked. Writing the correct key unlocks it, and writing any other key value locks it again. A count write made while locked is dropped and sets a sticky error bit.

The block has three resets. Power-on reset clears the count and stops it. Hard and soft resets leave the count, the enable bit and the interrupt state alone. They only lock the key gate again and clear the error bit. While they are asserted, counting continues.

Top module: `keyed_decrementer`

## Requirements
- R1: While `por_n` is low at a clock edge, the count goes to 0, the enable bit to 0, the pending flag to 0, the gate to locked and the error bit to 0.
- R2: The count drops by exactly 1 after each edge where `tb_tick` is high and the enable bit (control bit 0) is set, unless a count write is accepted. Otherwise the count holds.
- R3: `hard_rst_n` or `soft_rst_n` low locks the gate and clears the error bit. Neither reset changes the count, the enable bit or the pending flag, and counting continues while they are low.
- R4: `rdata` is a side-effect-free combinational view selected by `addr`. Address 0 gives the count. Address 1 gives the error bit in bit 1 and the enable bit in bit 0. Address 2 gives the lock state in bit 0, where 1 means unlocked. Address 3 reads zero.
- R5: A write to address 2 unlocks the gate when the data is 0x55CCAA33 and locks it for any other value.
- R6: A write to address 0 while unlocked loads `wdata` into the count at that edge. A write in the same cycle as a tick wins, and no decrement happens.
- R7: A write to address 0 while locked leaves the count unchanged and sets the error bit. Writing address 1 with bit 1 set clears the error bit, and bit 0 of that write sets the enable bit.
- R8: A 0-to-1 change of count bit 31 caused by counting, including the wrap from 0x00000000 to 0xFFFFFFFF, sets the pending flag one cycle after the new count is visible.
- R9: A 0-to-1 change of bit 31 caused by an accepted count write also sets the pending flag.
- R10: The pending flag stays set until `irq_ack` is sampled high. If further transitions occur while it is set, it remains a single flag. A transition in the same cycle as the acknowledge keeps the flag set.
- R11: `wake` is high for exactly one cycle for each 0-to-1 transition, at the same time the pending flag is set, including when the flag was already set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| hard_rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst_n | input | 1 | Soft reset, synchronous, active low |
| tb_tick | input | 1 | Single-cycle timebase tick enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_ack | input | 1 | Core has taken the interrupt |
| irq_pending | output | 1 | Sticky interrupt request |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
The hardest cases to reach are a fresh bit-31 rising edge that lands while a request is already pending, and the same edge landing in the same cycle as an acknowledge. A stimulus must unlock the gate, load the count next to a boundary, and then time a tick or a write against `irq_ack`. The directed part loads values such as 1 and 0x80000000 so that wraps and loaded edges come a few cycles apart. It also fires an acknowledge in exactly the event cycle. The random part gives the key its own high probability and picks count values near the sign boundary. This way unlock, reload and rising edges recur often while hard, soft and power-on resets land at arbitrary points.

// File: rtl/dec_pkg.sv
// Package: shared register map and constants for the keyed decrementer.
// Assumes a word-addressed port with two address bits.
package dec_pkg;

    typedef enum logic [1:0] {
        A_COUNT = 2'd0,
        A_CTRL  = 2'd1,
        A_KEY   = 2'd2,
        A_RSVD  = 2'd3
    } dec_addr_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_ERR_BIT = 1;

    localparam logic [31:0] UNLOCK_KEY = 32'h55CC_AA33;

endpackage

// File: rtl/dec_key_gate.sv
// Module: dec_key_gate
// Holds the unlock state and the sticky write-error bit. It turns a raw
// count-write request into an accepted write only while unlocked.
// Assumes: every reset is synchronous and active low. Any of the three
// resets locks the gate and clears the error bit.
module dec_key_gate
    import dec_pkg::*;
#(
    parameter int          W   = 32,
    parameter logic [W-1:0] KEY = W'(UNLOCK_KEY)
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         hard_rst_n,
    input  logic         soft_rst_n,
    input  logic         wr_en,
    input  dec_addr_e    addr,
    input  logic [W-1:0] wdata,
    output logic         unlocked,
    output logic         wr_err,
    output logic         cnt_wr_ok
);

    logic any_rst;
    logic key_wr;
    logic cnt_req;
    logic err_clr;

    // Decode the write strobes that concern the gate.
    always_comb begin
        any_rst   = !por_n || !hard_rst_n || !soft_rst_n;
        key_wr    = wr_en && (addr == A_KEY);
        cnt_req   = wr_en && (addr == A_COUNT);
        err_clr   = wr_en && (addr == A_CTRL) && wdata[CTRL_ERR_BIT];
        cnt_wr_ok = cnt_req && unlocked;
    end

    // Unlock on a matching key, relock on any other key value.
    always_ff @(posedge clk) begin
        if (any_rst) begin
            unlocked <= 1'b0;
        end else if (key_wr) begin
            unlocked <= (wdata == KEY);
        end
    end

    // Sticky error on a locked count write, cleared by write-one.
    always_ff @(posedge clk) begin
        if (any_rst) begin
            wr_err <= 1'b0;
        end else if (cnt_req && !unlocked) begin
            wr_err <= 1'b1;
        end else if (err_clr) begin
            wr_err <= 1'b0;
        end
    end

    AST_LOCKED_WR_ERR: assert property (@(posedge clk) disable iff (any_rst)
        (cnt_req && !unlocked) |=> wr_err); // R7

    AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (any_rst)
        (key_wr && (wdata != KEY)) |=> !unlocked); // R5

    AST_GOOD_KEY_OPENS: assert property (@(posedge clk) disable iff (any_rst)
        (key_wr && (wdata == KEY)) |=> unlocked); // R5

endmodule

// File: rtl/dec_counter.sv
// Module: dec_counter
// The down-counter and its enable bit. An accepted write has priority over
// a tick. Only power-on reset touches the count or the enable bit.
// Assumes: tick is a single-cycle enable in the clk domain.
module dec_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         tick,
    input  logic         ctrl_wr,
    input  logic         ctrl_en,
    input  logic         cnt_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic         enable
);

    localparam logic [W-1:0] ONE = W'(1);

    logic step;

    // A decrement is due when ticking, enabled and no write is accepted.
    always_comb begin
        step = tick && enable && !cnt_wr;
    end

    // Count register: load, decrement or hold.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            count <= '0;
        end else if (cnt_wr) begin
            count <= wdata;
        end else if (step) begin
            count <= count - ONE;
        end
    end

    // Enable bit, written through the control word.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            enable <= 1'b0;
        end else if (ctrl_wr) begin
            enable <= ctrl_en;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        (!cnt_wr && !(tick && enable)) |=> $stable(count)); // R2

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!por_n)
        (tick && enable && !cnt_wr) |=> (count == $past(count) - ONE)); // R2

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!por_n)
        cnt_wr |=> (count == $past(wdata))); // R6

endmodule

// File: rtl/dec_irq.sv
// Module: dec_irq
// Detects a 0-to-1 change of the counter MSB, keeps a single sticky
// pending flag and emits a one-cycle wake pulse per event.
// Assumes: msb comes from a register, so detection adds one cycle.
module dec_irq (
    input  logic clk,
    input  logic por_n,
    input  logic msb,
    input  logic ack,
    output logic pending,
    output logic wake
);

    logic msb_q;
    logic rise;

    // Edge detect against the previous MSB.
    always_comb begin
        rise = msb && !msb_q;
    end

    // Remember the last MSB value.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            msb_q <= 1'b0;
        end else begin
            msb_q <= msb;
        end
    end

    // Sticky request, where a new event outranks the acknowledge.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            pending <= 1'b0;
        end else if (rise) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

    // One-cycle wake pulse for every event.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            wake <= 1'b0;
        end else begin
            wake <= rise;
        end
    end

    AST_EVENT_PENDS: assert property (@(posedge clk) disable iff (!por_n)
        rise |=> pending); // R10

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        (ack && !rise) |=> !pending); // R10

    AST_WAKE_WITH_PEND: assert property (@(posedge clk) disable iff (!por_n)
        wake |-> pending); // R11

    AST_RISE_WAKES: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pending) |-> wake); // R11

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        wake |=> !wake); // R11

endmodule

// File: rtl/keyed_decrementer.sv
// Module: keyed_decrementer (top)
// A keyed 32-bit decrementer with an MSB-rise interrupt. It ties together
// the key gate, the counter and the interrupt logic, and muxes the read view.
// Assumes: synchronous active-low resets, and reads without side effects.
module keyed_decrementer
    import dec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         hard_rst_n,
    input  logic         soft_rst_n,
    input  logic         tb_tick,
    input  logic         wr_en,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    input  logic         irq_ack,
    output logic         irq_pending,
    output logic         wake
);

    dec_addr_e    a_sel;
    logic         unlocked;
    logic         wr_err;
    logic         cnt_wr_ok;
    logic         ctrl_wr;
    logic [W-1:0] count;
    logic         enable;

    // Cast the raw address and decode the control write.
    always_comb begin
        a_sel   = dec_addr_e'(addr);
        ctrl_wr = wr_en && (a_sel == A_CTRL);
    end

    dec_key_gate #(.W(W)) u_gate (
        .clk        (clk),
        .por_n      (por_n),
        .hard_rst_n (hard_rst_n),
        .soft_rst_n (soft_rst_n),
        .wr_en      (wr_en),
        .addr       (a_sel),
        .wdata      (wdata),
        .unlocked   (unlocked),
        .wr_err     (wr_err),
        .cnt_wr_ok  (cnt_wr_ok)
    );

    dec_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .por_n   (por_n),
        .tick    (tb_tick),
        .ctrl_wr (ctrl_wr),
        .ctrl_en (wdata[CTRL_EN_BIT]),
        .cnt_wr  (cnt_wr_ok),
        .wdata   (wdata),
        .count   (count),
        .enable  (enable)
    );

    dec_irq u_irq (
        .clk     (clk),
        .por_n   (por_n),
        .msb     (count[W-1]),
        .ack     (irq_ack),
        .pending (irq_pending),
        .wake    (wake)
    );

    // Read view selected by address, without side effects.
    always_comb begin
        rdata = '0;
        unique case (a_sel)
            A_COUNT: rdata = count;
            A_CTRL: begin
                rdata[CTRL_EN_BIT]  = enable;
                rdata[CTRL_ERR_BIT] = wr_err;
            end
            A_KEY:   rdata[0] = unlocked;
            A_RSVD:  rdata = '0;
        endcase
    end

    AST_LOCKED_NO_LOAD: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && (a_sel == A_COUNT) && !unlocked && !tb_tick) |=> $stable(count)); // R7

endmodule

// File: tb/keyed_decrementer_bench.sv
module keyed_decrementer_bench;

    localparam int  CLK_PERIOD = 10;
    localparam logic [31:0] KEY = 32'h55CC_AA33;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, hard_rst_n = 1'b1, soft_rst_n = 1'b1;
    logic        tb_tick = 1'b0, wr_en = 1'b0, irq_ack = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_pending, wake;

    int checks = 0;
    int failures = 0;

    // Reference state built from the requirements.
    logic [31:0] m_cnt = '0;
    logic m_en = 0, m_unl = 0, m_err = 0, m_pend = 0, m_wake = 0, m_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_decrementer u_keyed_decrementer (
        .clk(clk), .por_n(por_n), .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n),
        .tb_tick(tb_tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_ack(irq_ack), .irq_pending(irq_pending), .wake(wake)
    );

    function automatic logic [31:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return m_cnt;
            2'd1:    return {30'd0, m_err, m_en};
            2'd2:    return {31'd0, m_unl};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Advance the reference model by one edge with the given inputs.
    task automatic model_step(input logic p, input logic h, input logic s, input logic t,
                              input logic k, input logic w, input logic [1:0] a, input logic [31:0] d);
        logic ev;
        ev = m_cnt[31] && !m_prev;
        if (!p) begin
            m_cnt = 0; m_en = 0; m_pend = 0; m_wake = 0; m_prev = 0;
        end else begin
            m_pend = ev ? 1'b1 : (k ? 1'b0 : m_pend);
            m_wake = ev;
            m_prev = m_cnt[31];
            if (w && a == 2'd0 && m_unl) m_cnt = d;
            else if (t && m_en)          m_cnt = m_cnt - 1;
            if (w && a == 2'd1)          m_en = d[0];
        end
        if (!p || !h || !s) begin
            m_unl = 0; m_err = 0;
        end else begin
            if (w && a == 2'd2)                m_unl = (d == KEY);
            if (w && a == 2'd0 && !m_unl)      m_err = 1;
            else if (w && a == 2'd1 && d[1])   m_err = 0;
        end
    endtask

    // One cycle: drive at negedge, check the pre-edge view, step the model at posedge.
    task automatic cyc(input string tag, input logic p, input logic h, input logic s,
                       input logic t, input logic k, input logic w,
                       input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        por_n = p; hard_rst_n = h; soft_rst_n = s; tb_tick = t;
        irq_ack = k; wr_en = w; addr = a; wdata = d;
        #1;
        chk(tag, "rdata", rdata, exp_rdata(a));
        chk(tag, "irq_pending", {31'd0, irq_pending}, {31'd0, m_pend});
        chk(tag, "wake", {31'd0, wake}, {31'd0, m_wake});
        @(posedge clk);
        model_step(p, h, s, t, k, w, a, d);
    endtask

    task automatic rd(input string tag, input logic [1:0] a);
        cyc(tag, 1, 1, 1, 0, 0, 0, a, 0);
    endtask

    task automatic wr(input string tag, input logic [1:0] a, input logic [31:0] d);
        cyc(tag, 1, 1, 1, 0, 0, 1, a, d);
    endtask

    task automatic tk(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 1, 1, 1, 1, 0, 0, 2'd0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        // Power-on reset, which initializes the DUT before any check.
        repeat (3) @(posedge clk);
        model_step(0, 1, 1, 0, 0, 0, 0, 0);
        cyc("R1", 0, 1, 1, 1, 0, 0, 2'd0, 0);
        rd("R1", 2'd0); rd("R1", 2'd1); rd("R1", 2'd2); rd("R4", 2'd3);
        // Locked write is dropped and flags an error, and W1C clears it.
        wr("R7", 2'd0, 32'h0000_0010);
        rd("R7", 2'd0); rd("R7", 2'd1);
        wr("R7", 2'd1, 32'h2);
        rd("R7", 2'd1);
        // Key handling.
        wr("R5", 2'd2, 32'h1234_5678); rd("R5", 2'd2);
        wr("R5", 2'd2, KEY);           rd("R5", 2'd2);
        // Load, enable, count, and a write that outranks a tick.
        wr("R6", 2'd0, 32'd5); rd("R6", 2'd0);
        wr("R2", 2'd1, 32'h1);
        tk("R2", 3); rd("R2", 2'd0);
        cyc("R6", 1, 1, 1, 1, 0, 1, 2'd0, 32'd20); rd("R6", 2'd0);
        // A write sets the MSB and raises a request.
        wr("R9", 2'd0, 32'h8000_0001); rd("R9", 2'd0); rd("R9", 2'd0); rd("R11", 2'd0);
        cyc("R10", 1, 1, 1, 0, 1, 0, 2'd0, 0); rd("R10", 2'd0);
        // Wrap through zero.
        wr("R8", 2'd0, 32'd1);
        tk("R8", 2); rd("R8", 2'd0); rd("R8", 2'd0); rd("R11", 2'd0);
        // Second event while pending, then an ack in the event cycle.
        wr("R10", 2'd0, 32'd0); wr("R10", 2'd0, 32'h8000_0000);
        cyc("R10", 1, 1, 1, 0, 1, 0, 2'd0, 0);
        rd("R11", 2'd0); rd("R10", 2'd0);
        cyc("R10", 1, 1, 1, 0, 1, 0, 2'd0, 0); rd("R10", 2'd0);
        // Hard and soft resets: counting goes on, gate relocks.
        wr("R3", 2'd0, 32'd100);
        cyc("R3", 1, 0, 1, 1, 0, 0, 2'd0, 0);
        cyc("R3", 1, 0, 1, 1, 0, 0, 2'd0, 0);
        cyc("R3", 1, 1, 0, 1, 0, 0, 2'd1, 0);
        rd("R3", 2'd0); rd("R3", 2'd2); rd("R3", 2'd1);
        wr("R3", 2'd0, 32'd7); rd("R3", 2'd0);
        // Constrained random mix.
        for (int n = 0; n < 6000; n++) begin
            logic p, h, s, t, k, w;
            logic [1:0] a;
            logic [31:0] d;
            int sel;
            p = ($urandom_range(0, 599) != 0);
            h = ($urandom_range(0, 59) != 0);
            s = ($urandom_range(0, 59) != 0);
            t = $urandom_range(0, 1) == 1;
            k = ($urandom_range(0, 7) == 0);
            w = ($urandom_range(0, 3) == 0);
            a = 2'($urandom_range(0, 3));
            sel = $urandom_range(0, 5);
            case (sel)
                0: d = 32'd0;
                1: d = 32'd2;
                2: d = 32'h8000_0000;
                3: d = 32'h7FFF_FFFF;
                4: d = $urandom();
                default: d = {31'd0, 1'b1};
            endcase
            if (a == 2'd2 && $urandom_range(0, 2) != 0) d = KEY;
            if (a == 2'd1) d[0] = ($urandom_range(0, 3) != 0);
            cyc("R2/R8/R10 random", p, h, s, t, k, w, a, d);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule